// File: doc/BRIEF.md
# Outstanding-Miss Waiting Store

This block parks load references that missed in a data cache, whether the word is absent or still in transit, so the processor keeps issuing instead of stalling. Each parked entry keeps the word address it waits for and the destination register tag of the load. When memory hands back a word, every parked entry for that address is released to the processor, and each release also clears that register's reservation. A later instruction stalls only if it reads a register that is still reserved. That scoreboard lives outside this block.

The store holds up to `DEPTH` entries. This is the only limit on outstanding misses. There is no limit per address or per bank. A reference to an address that already has a parked entry, or that is currently being drained, is parked without raising a fresh memory request. When the store is full, `ref_ready` falls and the cache must hold the reference back. A returning word is captured in one cycle. Its matching entries then leave one per cycle, oldest first, and no further word is accepted until the last of them has gone. A word that nobody waits for is accepted and dropped.

Top module: `miss_wait_store`

## Requirements
- R1: `ref_ready` is high exactly when fewer than `DEPTH` entries are parked. A reference offered while `ref_ready` is low is not stored and raises no memory request.
- R2: An accepted reference raises `mreq_valid`, with `mreq_addr` equal to its address, in the same cycle. This happens only when no parked entry holds that address and the word being drained is not that address.
- R3: A returning word accepted at a clock edge starts releasing in the next cycle. Each matching entry is released once, one per cycle, in the order it was parked. Each release carries the entry's tag on `wake_tag` and the returned word on `wake_data`.
- R4: `ret_ready` is low from the edge that accepts a word with waiting entries until the edge that releases the last of them. A word with no waiting entry leaves `ret_ready` high and produces no release.
- R5: Entries for other addresses stay parked through a drain, keep their relative order, and are released by their own word later.
- R6: Each release frees one entry. A store that was full raises `ref_ready` again after the edge at which a release happens.
- R7: After reset the store is empty: `ref_ready` and `ret_ready` are high, and `wake_valid` and `mreq_valid` are low.
- R8: All `DEPTH` entries may wait on one address. Exactly one memory request is raised for them, and exactly `DEPTH` releases follow that address's return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A missing load reference is offered |
| ref_ready | output | 1 | Store has a free entry |
| ref_addr | input | AW | Word address the load waits for |
| ref_tag | input | TW | Destination register tag of the load |
| mreq_valid | output | 1 | A fresh memory request is needed |
| mreq_addr | output | AW | Address of the fresh request |
| ret_valid | input | 1 | A word is returning from memory |
| ret_ready | output | 1 | A returning word can be taken |
| ret_addr | input | AW | Address of the returning word |
| ret_data | input | DW | Returning word |
| wake_valid | output | 1 | An entry is released; its register reservation clears |
| wake_tag | output | TW | Register tag being released |
| wake_data | output | DW | Word delivered with the release |

## Verification
`ref_ready`, `ret_ready`, `mreq_valid` and the release outputs are all combinational from the stored state and the current inputs. The bench drives inputs just after a falling edge and compares every output one time unit later, in the same cycle. The expected values come from a queue model in the bench. The model advances only after the rising edge, so a returned word first appears on the release outputs in the cycle after its acceptance. A freed entry shows up on `ref_ready` in the cycle after its release.

// File: rtl/miss_wait_store.sv
module miss_wait_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  output logic          ref_ready,
  input  logic [AW-1:0] ref_addr,
  input  logic [TW-1:0] ref_tag,
  output logic          mreq_valid,
  output logic [AW-1:0] mreq_addr,
  input  logic          ret_valid,
  output logic          ret_ready,
  input  logic [AW-1:0] ret_addr,
  input  logic [DW-1:0] ret_data,
  output logic          wake_valid,
  output logic [TW-1:0] wake_tag,
  output logic [DW-1:0] wake_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [TW-1:0]    tag_q  [DEPTH];
  logic [AW-1:0]    addr_n [DEPTH];
  logic [TW-1:0]    tag_n  [DEPTH];
  logic [CW-1:0]    cnt;
  logic             busy;
  logic [AW-1:0]    hold_a;
  logic [DW-1:0]    hold_d;
  logic [DEPTH-1:0] key_m, ref_m;
  logic [IW-1:0]    rk;
  logic [CW-1:0]    wpos;

  wire [AW-1:0] key = busy ? hold_a : ret_addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    wire live = CW'(i) < cnt;
    assign key_m[i] = live && (addr_q[i] == key);
    assign ref_m[i] = live && (addr_q[i] == ref_addr);
  end

  wire enq     = ref_valid && ref_ready;
  wire ret_acc = ret_valid && !busy;
  wire multi   = |(key_m & (key_m - 1'b1));
  wire inc     = enq && (ref_addr == key);
  wire hit     = (|ref_m) || (busy && (ref_addr == hold_a));

  assign ref_ready  = cnt != CW'(DEPTH);
  assign ret_ready  = !busy;
  assign wake_valid = busy && (|key_m);
  assign mreq_valid = enq && !hit;
  assign mreq_addr  = ref_addr;
  assign wake_data  = hold_d;
  assign wake_tag   = tag_q[rk];
  assign wpos       = cnt - CW'(wake_valid);

  always_comb begin
    rk = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (key_m[i]) rk = IW'(i);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = (i < DEPTH - 1) ? i + 1 : i;
      if (wake_valid && (IW'(i) >= rk)) begin
        addr_n[i] = addr_q[j];
        tag_n[i]  = tag_q[j];
      end else begin
        addr_n[i] = addr_q[i];
        tag_n[i]  = tag_q[i];
      end
    end
    if (enq) begin
      addr_n[wpos[IW-1:0]] = ref_addr;
      tag_n[wpos[IW-1:0]]  = ref_tag;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      addr_q[i] <= addr_n[i];
      tag_q[i]  <= tag_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      hold_a <= '0;
      hold_d <= '0;
    end else begin
      cnt <= cnt + CW'(enq) - CW'(wake_valid);
      if (busy) busy <= multi || inc;
      else      busy <= ret_acc && ((|key_m) || inc);
      if (ret_acc) begin
        hold_a <= ret_addr;
        hold_d <= ret_data;
      end
    end
  end
endmodule

// File: rtl/miss_wait_store_chk.sv
module miss_wait_store_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 6,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ref_valid,
  input logic                       ref_ready,
  input logic [AW-1:0]              ref_addr,
  input logic                       mreq_valid,
  input logic [AW-1:0]              mreq_addr,
  input logic                       ret_ready,
  input logic                       wake_valid,
  input logic [DW-1:0]              wake_data,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R1
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ($clog2(DEPTH+1))'(DEPTH)) |-> !ref_ready); // R1
  AST_MREQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (ref_valid && ref_ready && mreq_addr == ref_addr)); // R2
  AST_WAKE_BLOCKS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> !ret_ready); // R4
  AST_DRAIN_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && $past(wake_valid) && $past(rst_n)) |-> $stable(wake_data)); // R3
endmodule

bind miss_wait_store miss_wait_store_chk #(
  .DEPTH(DEPTH), .AW(AW), .TW(TW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .ref_addr(ref_addr), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
  .ret_ready(ret_ready), .wake_valid(wake_valid), .wake_data(wake_data),
  .cnt(cnt)
);

// File: tb/miss_wait_store_test.sv
module miss_wait_store_test;
  localparam int DEPTH = 8;
  localparam int AW = 12;
  localparam int TW = 5;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0, ret_valid = 1'b0;
  logic [AW-1:0] ref_addr = '0, ret_addr = '0;
  logic [TW-1:0] ref_tag = '0;
  logic [DW-1:0] ret_data = '0;
  logic ref_ready, mreq_valid, ret_ready, wake_valid;
  logic [AW-1:0] mreq_addr;
  logic [TW-1:0] wake_tag;
  logic [DW-1:0] wake_data;

  always #4 clk = ~clk;

  miss_wait_store #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_addr(ref_addr), .ref_tag(ref_tag),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_addr(ret_addr), .ret_data(ret_data),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_data(wake_data));

  int n_chk = 0, n_bad = 0;
  int n_wake = 0, n_mreq = 0;
  bit done = 0;

  logic [AW-1:0] qa [DEPTH];
  logic [TW-1:0] qt [DEPTH];
  int qn = 0;
  bit mbusy = 0;
  logic [AW-1:0] mh_a = '0;
  logic [DW-1:0] mh_d = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit rv, logic [AW-1:0] ra, logic [TW-1:0] rt,
                      bit tv, logic [AW-1:0] ta, logic [DW-1:0] td);
    int k;
    bit e_rr, e_enq, e_hit, acc, any;
    ref_valid = rv; ref_addr = ra; ref_tag = rt;
    ret_valid = tv; ret_addr = ta; ret_data = td;
    #1;
    e_rr = qn < DEPTH;
    k = -1;
    if (mbusy)
      for (int i = 0; i < qn; i++) if (k < 0 && qa[i] == mh_a) k = i;
    e_enq = rv && e_rr;
    e_hit = mbusy && ra == mh_a;
    for (int i = 0; i < qn; i++) if (qa[i] == ra) e_hit = 1;
    check("R1 R6", "ref_ready", 32'(ref_ready), 32'(e_rr));
    check("R4", "ret_ready", 32'(ret_ready), 32'(!mbusy));
    check("R3", "wake_valid", 32'(wake_valid), 32'(k >= 0));
    if (k >= 0) begin
      check("R3 R5", "wake_tag", 32'(wake_tag), 32'(qt[k]));
      check("R3", "wake_data", 32'(wake_data), 32'(mh_d));
      n_wake++;
    end
    check("R2", "mreq_valid", 32'(mreq_valid), 32'(e_enq && !e_hit));
    if (e_enq && !e_hit) begin
      check("R2", "mreq_addr", 32'(mreq_addr), 32'(ra));
      n_mreq++;
    end
    @(posedge clk);
    #1;
    if (k >= 0) begin
      for (int i = k; i < qn - 1; i++) begin qa[i] = qa[i+1]; qt[i] = qt[i+1]; end
      qn--;
    end
    if (e_enq) begin qa[qn] = ra; qt[qn] = rt; qn++; end
    acc = tv && !mbusy;
    if (acc) begin mh_a = ta; mh_d = td; end
    any = 0;
    for (int i = 0; i < qn; i++) if (qa[i] == mh_a) any = 1;
    mbusy = (mbusy || acc) && any;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0);
  endtask

  initial begin
    int w0, m0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7", "ref_ready", 32'(ref_ready), 1);
    check("R7", "ret_ready", 32'(ret_ready), 1);
    check("R7", "wake_valid", 32'(wake_valid), 0);
    check("R7", "mreq_valid", 32'(mreq_valid), 0);
    @(negedge clk);

    // R8: fill every entry on one address, then one extra offer while full (R1)
    m0 = n_mreq;
    for (int i = 0; i < DEPTH; i++) step(1, 12'h010, TW'(i + 1), 0, '0, '0);
    step(1, 12'h010, 5'h1f, 0, '0, '0);
    check("R8", "requests for one address", 32'(n_mreq - m0), 1);
    w0 = n_wake;
    step(0, '0, '0, 1, 12'h010, 16'hbeef);
    for (int i = 0; i < DEPTH + 2; i++) idle();
    check("R8", "releases for one address", 32'(n_wake - w0), DEPTH);

    // R4: a word nobody waits for
    w0 = n_wake;
    step(0, '0, '0, 1, 12'h055, 16'h1234);
    idle(); idle();
    check("R4", "releases for unmatched word", 32'(n_wake - w0), 0);

    // R5: interleaved addresses, drain one while the other stays
    step(1, 12'h0a0, 5'd3, 0, '0, '0);
    step(1, 12'h0b0, 5'd4, 0, '0, '0);
    step(1, 12'h0a0, 5'd5, 0, '0, '0);
    step(1, 12'h0b0, 5'd6, 1, 12'h0b0, 16'h0b0b);
    step(1, 12'h0b0, 5'd7, 0, '0, '0);
    for (int i = 0; i < 4; i++) idle();
    step(0, '0, '0, 1, 12'h0a0, 16'h0a0a);
    for (int i = 0; i < 4; i++) idle();
    check("R5", "store empty after both drains", 32'(ref_ready), 1);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      bit rv, tv;
      logic [AW-1:0] ra, ta;
      rv = ($urandom % 2) == 0;
      tv = ($urandom % 10) < 3;
      ra = AW'(12'h100 + ($urandom % 4));
      ta = AW'(12'h100 + ($urandom % 5));
      step(rv, ra, TW'($urandom), tv, ta, DW'($urandom));
    end
    for (int i = 0; i < 3 * DEPTH; i++) step(0, '0, '0, 1, AW'(12'h100 + (i % 5)), DW'(i));

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule